// File: doc/BRIEF.md
# Bidirectional Inverting Latched Bus Transceiver

This block is a narrow buffer register placed between two data ports, A and B, in a memory data path. Two input enables choose which port supplies data. The other port is the one the block drives. A level-sensitive store sits on the path between them. While the latch-open control is high, the store follows the source port, so data reaches the far side with no clock edge. When the control falls, the store freezes the value present at that moment.

The stored word always leaves the block inverted, in both directions. Each port has its own output-disable input. A shared expansion input forces both ports off, so several of these registers can be multiplexed onto the same lines. Capture into the store depends only on the enables and the latch-open control. A word can therefore be taken in while every output is off.

Each pin is modelled as a separate input bus, output bus and per-port output enable. A pad or tri-state wrapper at a higher level joins them.

Top module: `inv_latch_xcvr`

## Requirements
- R1: After `rst_n` is released and before any capture, the store holds all zeros, so a driven port shows all ones (4'hF at the default width).
- R2: With `en_a`=1 and `en_b`=0, port B is the driven port (`b_oe`=1 unless it is disabled). With `en_a`=0 and `en_b`=1, port A is the driven port (`a_oe`=1 unless it is disabled).
- R3: While `lat_open`=1 and exactly one enable is high, the driven port's data equals the bitwise complement of the source port's input in the same cycle.
- R4: When `lat_open` falls, the value present at that moment is kept. Later changes on the source input leave the driven data unchanged while `lat_open` stays 0.
- R5: The inversion applies in both directions: A-to-B gives `b_out` = ~`a_in`, and B-to-A gives `a_out` = ~`b_in`, bit by bit.
- R6: `dis_a`=1 forces `a_oe`=0 and `dis_b`=1 forces `b_oe`=0. The two disables act independently, and both may be set at once.
- R7: `expand`=1 forces `a_oe`=0 and `b_oe`=0 regardless of the enables, `lat_open` and the disables.
- R8: A word is captured while disables or `expand` are asserted. After the outputs are re-enabled with `lat_open`=0, the driven port shows the complement of that word.
- R9: The source port is never driven: `en_a`=1 implies `a_oe`=0, and `en_b`=1 implies `b_oe`=0.
- R10: When `en_a` equals `en_b`, neither port is driven and the store keeps its contents. This is observed by returning to a valid direction with `lat_open`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset; clears the store |
| en_a | input | 1 | Selects port A as the source |
| en_b | input | 1 | Selects port B as the source |
| lat_open | input | 1 | 1: store follows source; 0: store holds |
| dis_a | input | 1 | Turns off the port A output |
| dis_b | input | 1 | Turns off the port B output |
| expand | input | 1 | Turns off both port outputs |
| a_in | input | W | Values seen on the port A pins |
| b_in | input | W | Values seen on the port B pins |
| a_out | output | W | Data for the port A pins (inverted store) |
| a_oe | output | 1 | Drive enable for the port A pins |
| b_out | output | W | Data for the port B pins (inverted store) |
| b_oe | output | 1 | Drive enable for the port B pins |

## Verification
A corrupted store shows up only on a driven port, and only once `lat_open` is low. While the latch is open, the fresh source data hides the fault, so the bench compares held words after direction changes, disabled periods and equal-enable periods. A fault in the output-enable path is different. It shows on `a_oe` or `b_oe` in the same cycle as the control change, with no latency to wait out.

// File: rtl/inv_latch_xcvr_pkg.sv
package inv_latch_xcvr_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'b00,
    DIR_A2B  = 2'b01,
    DIR_B2A  = 2'b10
  } dir_e;

  function automatic dir_e dir_of(input logic ena, input logic enb);
    if (ena && !enb)      return DIR_A2B;
    else if (!ena && enb) return DIR_B2A;
    else                  return DIR_IDLE;
  endfunction

  function automatic logic port_drive(input logic sel, input logic dis,
                                      input logic exp);
    return sel && !dis && !exp;
  endfunction

endpackage

// File: rtl/xcvr_dir_decode.sv
module xcvr_dir_decode
  import inv_latch_xcvr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         en_a,
  input  logic         en_b,
  input  logic         lat_open,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output dir_e         dir,
  output logic         load,
  output logic [W-1:0] src
);
  always_comb begin
    dir  = dir_of(en_a, en_b);
    load = lat_open && (dir != DIR_IDLE);
    src  = (dir == DIR_B2A) ? b_in : a_in;
  end
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 4
) (
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (!rst_n)    q = '0;
    else if (load) q = d;
  end
endmodule

// File: rtl/xcvr_out_port.sv
module xcvr_out_port
  import inv_latch_xcvr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         sel,
  input  logic         dis,
  input  logic         exp,
  input  logic [W-1:0] q,
  output logic [W-1:0] dout,
  output logic         oe
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = ~q[i];
  end
  assign oe = port_drive(sel, dis, exp);
endmodule

// File: rtl/inv_latch_xcvr.sv
module inv_latch_xcvr
  import inv_latch_xcvr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         rst_n,
  input  logic         en_a,
  input  logic         en_b,
  input  logic         lat_open,
  input  logic         dis_a,
  input  logic         dis_b,
  input  logic         expand,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  dir_e         dir;
  logic         load;
  logic [W-1:0] src;
  logic [W-1:0] store_q;
  logic         sel_a, sel_b;

  xcvr_dir_decode #(.W(W)) u_dec (
    .en_a(en_a), .en_b(en_b), .lat_open(lat_open),
    .a_in(a_in), .b_in(b_in),
    .dir(dir), .load(load), .src(src)
  );

  xcvr_store #(.W(W)) u_store (
    .rst_n(rst_n), .load(load), .d(src), .q(store_q)
  );

  assign sel_a = (dir == DIR_B2A);
  assign sel_b = (dir == DIR_A2B);

  xcvr_out_port #(.W(W)) u_port_a (
    .sel(sel_a), .dis(dis_a), .exp(expand), .q(store_q),
    .dout(a_out), .oe(a_oe)
  );

  xcvr_out_port #(.W(W)) u_port_b (
    .sel(sel_b), .dis(dis_b), .exp(expand), .q(store_q),
    .dout(b_out), .oe(b_oe)
  );
endmodule

// File: rtl/inv_latch_xcvr_chk.sv
module inv_latch_xcvr_chk #(
  parameter int W = 4
) (
  input logic         rst_n,
  input logic         en_a,
  input logic         en_b,
  input logic         lat_open,
  input logic         dis_a,
  input logic         dis_b,
  input logic         expand,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  always_comb begin
    if (rst_n) begin
      // R7
      expand_off_chk: assert (!expand || (!a_oe && !b_oe));
      // R9
      src_not_driven_chk: assert (!(en_a && a_oe) && !(en_b && b_oe));
      // R6
      disable_off_chk: assert (!(dis_a && a_oe) && !(dis_b && b_oe));
      // R10
      idle_off_chk: assert ((en_a != en_b) || (!a_oe && !b_oe));
      // R3
      fall_through_chk: assert (!(lat_open && en_a && !en_b) || (b_out == ~a_in));
      // R5
      invert_b2a_chk: assert (!(lat_open && !en_a && en_b) || (a_out == ~b_in));
    end
  end
endmodule

bind inv_latch_xcvr inv_latch_xcvr_chk #(.W(W)) u_chk (
  .rst_n(rst_n), .en_a(en_a), .en_b(en_b), .lat_open(lat_open),
  .dis_a(dis_a), .dis_b(dis_b), .expand(expand),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
  .b_out(b_out), .b_oe(b_oe)
);

// File: tb/inv_latch_xcvr_tb.sv
module inv_latch_xcvr_tb;
  localparam int W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, en_a, en_b, lat_open, dis_a, dis_b, expand;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] mdl_q;

  inv_latch_xcvr #(.W(W)) u_dut (
    .rst_n(rst_n), .en_a(en_a), .en_b(en_b), .lat_open(lat_open),
    .dis_a(dis_a), .dis_b(dis_b), .expand(expand),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic exp_oe_a(logic ea, logic eb, logic da, logic ex);
    return (eb & ~ea) & ~(da | ex);
  endfunction
  function automatic logic exp_oe_b(logic ea, logic eb, logic db, logic ex);
    return (ea & ~eb) & ~(db | ex);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic ea, logic eb, logic lo, logic da, logic db,
                       logic ex, logic [W-1:0] av, logic [W-1:0] bv);
    @(negedge clk);
    en_a = ea; en_b = eb; lat_open = lo; dis_a = da; dis_b = db;
    expand = ex; a_in = av; b_in = bv;
    if (lo && (ea != eb)) mdl_q = ea ? av : bv;
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; en_a = 0; en_b = 0; lat_open = 0; dis_a = 0; dis_b = 0;
    expand = 0; a_in = '0; b_in = '0; mdl_q = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset contents appear as all ones on the driven port
    drive(1, 0, 0, 0, 0, 0, 4'h5, 4'h0);
    chk("R1 b_out", b_out, 4'hF);
    chk("R2 b_oe", {3'b0, b_oe}, 4'h1);
    chk("R9 a_oe", {3'b0, a_oe}, 4'h0);

    // R3/R5 fall-through A to B
    drive(1, 0, 1, 0, 0, 0, 4'hA, 4'h3);
    chk("R3 b_out", b_out, 4'h5);
    // R4 hold then change source
    drive(1, 0, 0, 0, 0, 0, 4'hA, 4'h3);
    drive(1, 0, 0, 0, 0, 0, 4'h1, 4'h3);
    chk("R4 b_out held", b_out, 4'h5);

    // R5 B to A direction
    drive(0, 1, 1, 0, 0, 0, 4'h0, 4'hC);
    chk("R5 a_out", a_out, 4'h3);
    chk("R2 a_oe", {3'b0, a_oe}, 4'h1);
    chk("R9 b_oe", {3'b0, b_oe}, 4'h0);

    // R10 equal enables: nothing driven, store kept
    drive(1, 1, 1, 0, 0, 0, 4'h7, 4'h9);
    chk("R10 oe both", {2'b0, a_oe, b_oe}, 4'h0);
    drive(0, 0, 1, 0, 0, 0, 4'h6, 4'h6);
    chk("R10 oe none", {2'b0, a_oe, b_oe}, 4'h0);
    drive(0, 1, 0, 0, 0, 0, 4'h0, 4'h0);
    chk("R10 store kept", a_out, 4'h3);

    // R6 disables
    drive(0, 1, 0, 1, 0, 0, 4'h0, 4'h0);
    chk("R6 dis_a", {3'b0, a_oe}, 4'h0);
    drive(1, 0, 0, 0, 1, 0, 4'h0, 4'h0);
    chk("R6 dis_b", {3'b0, b_oe}, 4'h0);

    // R7 + R8 capture under expand, then re-enable
    drive(1, 0, 1, 0, 0, 1, 4'h6, 4'h0);
    chk("R7 expand", {2'b0, a_oe, b_oe}, 4'h0);
    drive(1, 0, 0, 0, 0, 1, 4'h6, 4'h0);
    drive(1, 0, 0, 0, 0, 0, 4'hF, 4'h0);
    chk("R8 b_out", b_out, 4'h9);
    // R8 capture under both disables, read on other port
    drive(0, 1, 1, 1, 1, 0, 4'h0, 4'hE);
    drive(0, 1, 0, 1, 1, 0, 4'h0, 4'hE);
    drive(0, 1, 0, 0, 0, 0, 4'h0, 4'h2);
    chk("R8 a_out", a_out, 4'h1);

    // random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 500; k++) begin
      logic [9:0] r;
      r = 10'($urandom);
      drive(r[0], r[1], r[2], r[3] & r[8], r[4] & r[9], r[5] & r[6] & r[7],
            4'($urandom), 4'($urandom));
      chk("R2/R6/R7/R9 a_oe", {3'b0, a_oe},
          {3'b0, exp_oe_a(en_a, en_b, dis_a, expand)});
      chk("R2/R6/R7/R9 b_oe", {3'b0, b_oe},
          {3'b0, exp_oe_b(en_a, en_b, dis_b, expand)});
      if (a_oe) chk("R4/R5 a_out", a_out, ~mdl_q);
      if (b_oe) chk("R3/R4 b_out", b_out, ~mdl_q);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule